// File: doc/BRIEF.md
# Programmable MMIO Window Router

This block sits on the processor side of an I/O hub. It decides which of several downstream bus bridges should receive a memory-mapped access. Software programs a small set of direct windows. Each window is described by three 64-bit registers: a start register, a size mask and a target selector.

The router turns each programmed window into an effective window in the top 4 GB of the 64-bit space. It then compares every incoming address with all enabled windows and returns a response one cycle later. The response gives the selected bridge and the offset of the address into the window, or a decode error when no window claims the address.

Registers are written through a 64-bit register port. That port accepts full 8-byte writes and 4-byte half-word writes. Every register can be read back through the same port. The data path to the bridges is not part of this block.

Top module: `mmio_window_router`

## Requirements
- R1: After reset every window register reads as zero, every window is disabled, and no response is valid until a request arrives.
- R2: Window n owns three registers at byte offsets 0x300+24n (start), +8 (size mask) and +16 (target). A 4-byte write changes only bits 63:32 when address bit 2 is 1, and only bits 31:0 when it is 0. A write outside 0x300..0x35F changes nothing, and a read there returns zero.
- R3: An 8-byte write replaces all 64 bits of the addressed register.
- R4: Bit 0 of the start register enables the window. While it is 0, the window never matches.
- R5: A window whose computed size is zero never matches, even when it is enabled.
- R6: The effective start is 0xFFFFFFFF in bits 63:32. Bits 31:12 come from the start register, and bits 11:0 are zero. Bits 63:32 of the start register have no effect.
- R7: The window size is the two's complement of mask bits 31:0, truncated to 32 bits and rounded down to a multiple of 4096. Mask bits 63:32 have no effect. An address matches when start <= address < start + size.
- R8: The reported target is the target register taken modulo the number of bridges (its low 2 bits for four bridges).
- R9: When several windows match, the lowest-numbered window decides target and offset.
- R10: A request that no window matches gives a response with the error flag set, the hit flag clear, and target and offset both zero. Exactly one of hit and error is set in every valid response.
- R11: On a hit, the offset equals the request address minus the effective start of the selected window.
- R12: A register write takes effect for a request sampled on the very next clock edge.
- R13: A response appears exactly one cycle after a request. When no request was made, the response valid, hit and error flags are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 8-byte write, 0 = 4-byte write |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 64 | Write data (bits 31:0 used for 4-byte writes) |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 64 | Read data, registered, valid the cycle after reg_rd |
| dec_valid | input | 1 | Decode request strobe |
| dec_addr | input | 64 | Address to decode |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Some window matched |
| rsp_err | output | 1 | No window matched (decode error) |
| rsp_target | output | 2 | Selected bridge index |
| rsp_offset | output | 64 | Address offset within the selected window |

## Verification
The hardest situations to reach from the ports are window edges and overlaps between windows. These include the last byte of a window, the first byte past it, a mask whose size rounds down to zero, and two enabled windows that cover the same address.

Random addresses almost never land in these places. The stimulus therefore builds each address from a chosen window's effective start plus an offset, so most requests fall inside or just outside a real window. Masks are drawn as page-sized powers of two, some of which round down to zero. Directed cases add exact boundary addresses, overlapping windows, and half-word updates issued just before a request.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  // three 64-bit registers per window, order is decoded by the register file
  localparam int REGS_PER_WIN = 3;
  localparam int WORD_BYTES   = 8;

  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_SIZE   = 2'd1,
    FLD_TARGET = 2'd2
  } win_field_e;

  function automatic logic [31:0] page_keep(input int page_bits);
    return ~((32'h1 << page_bits) - 32'h1);
  endfunction
endpackage

// File: rtl/mwr_regfile.sv
module mwr_regfile
  import mwr_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] REG_BASE = 12'h300,
  parameter int ROUTE_W = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr,
  input  logic                             wide,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [63:0]                      wdata,
  input  logic                             rd,
  output logic [63:0]                      rdata,
  output logic [NUM_WIN-1:0][31:0]         start_lo,
  output logic [NUM_WIN-1:0][31:0]         mask_lo,
  output logic [NUM_WIN-1:0][ROUTE_W-1:0]  route_lo
);
  localparam int NREGS = NUM_WIN * REGS_PER_WIN;
  localparam int IDX_W = $clog2(NREGS);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NREGS * WORD_BYTES);

  logic [63:0]       regs [NREGS];
  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic              in_blk;

  assign rel    = addr - REG_BASE;
  assign in_blk = (addr >= REG_BASE) && (rel < SPAN);
  assign idx    = rel[IDX_W+2:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr && in_blk) begin
      if (wide)        regs[idx]        <= wdata;
      else if (rel[2]) regs[idx][63:32] <= wdata[31:0];
      else             regs[idx][31:0]  <= wdata[31:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (rd && in_blk)  rdata <= regs[idx];
    else                    rdata <= '0;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_fields
    assign start_lo[w] = regs[w*REGS_PER_WIN + int'(FLD_START)][31:0];
    assign mask_lo[w]  = regs[w*REGS_PER_WIN + int'(FLD_SIZE)][31:0];
    assign route_lo[w] = regs[w*REGS_PER_WIN + int'(FLD_TARGET)][ROUTE_W-1:0];
  end
endmodule

// File: rtl/mwr_window.sv
module mwr_window
  import mwr_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int ROUTE_W   = 2
) (
  input  logic [31:0]        start_lo,
  input  logic [31:0]        mask_lo,
  input  logic [ROUTE_W-1:0] route,
  input  logic [63:0]        addr,
  output logic               hit,
  output logic [ROUTE_W-1:0] tgt,
  output logic [63:0]        offset
);
  localparam logic [31:0] KEEP = page_keep(PAGE_BITS);

  logic [63:0] eff_start;
  logic [31:0] size;
  logic        active;

  assign eff_start = {32'hFFFF_FFFF, start_lo & KEEP};
  assign size      = (~mask_lo + 32'h1) & KEEP;
  assign active    = start_lo[0] && (size != 32'h0);
  assign offset    = addr - eff_start;
  assign hit       = active && (addr >= eff_start) && (offset < {32'h0, size});
  assign tgt       = route;
endmodule

// File: rtl/mwr_pick.sv
module mwr_pick #(
  parameter int NUM_WIN = 4,
  parameter int ROUTE_W = 2
) (
  input  logic [NUM_WIN-1:0]               hit,
  input  logic [NUM_WIN-1:0][ROUTE_W-1:0]  tgt,
  input  logic [NUM_WIN-1:0][63:0]         offset,
  output logic                             any,
  output logic [ROUTE_W-1:0]               tgt_o,
  output logic [63:0]                      offset_o
);
  always_comb begin
    tgt_o    = '0;
    offset_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        tgt_o    = tgt[i];
        offset_o = offset[i];
      end
    end
  end
  assign any = |hit;
endmodule

// File: rtl/mmio_window_router.sv
module mmio_window_router #(
  parameter int NUM_WIN     = 4,
  parameter int NUM_TARGETS = 4,
  parameter int ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] REG_BASE = 12'h300,
  parameter int PAGE_BITS   = 12,
  localparam int TGT_W      = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_wide,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [63:0]       reg_rdata,
  input  logic              dec_valid,
  input  logic [63:0]       dec_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic [TGT_W-1:0]  rsp_target,
  output logic [63:0]       rsp_offset
);
  logic [NUM_WIN-1:0][31:0]       start_lo;
  logic [NUM_WIN-1:0][31:0]       mask_lo;
  logic [NUM_WIN-1:0][TGT_W-1:0]  route_lo;
  logic [NUM_WIN-1:0]             win_hit;
  logic [NUM_WIN-1:0][TGT_W-1:0]  win_tgt;
  logic [NUM_WIN-1:0][63:0]       win_off;
  logic                           any_hit;
  logic [TGT_W-1:0]               sel_tgt;
  logic [63:0]                    sel_off;

  mwr_regfile #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .ROUTE_W(TGT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .wide(reg_wide), .addr(reg_addr),
    .wdata(reg_wdata), .rd(reg_rd), .rdata(reg_rdata),
    .start_lo(start_lo), .mask_lo(mask_lo), .route_lo(route_lo)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    mwr_window #(.PAGE_BITS(PAGE_BITS), .ROUTE_W(TGT_W)) u_win (
      .start_lo(start_lo[w]), .mask_lo(mask_lo[w]), .route(route_lo[w]),
      .addr(dec_addr), .hit(win_hit[w]), .tgt(win_tgt[w]), .offset(win_off[w])
    );
  end

  mwr_pick #(.NUM_WIN(NUM_WIN), .ROUTE_W(TGT_W)) u_pick (
    .hit(win_hit), .tgt(win_tgt), .offset(win_off),
    .any(any_hit), .tgt_o(sel_tgt), .offset_o(sel_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_target <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid  <= dec_valid;
      rsp_hit    <= dec_valid && any_hit;
      rsp_err    <= dec_valid && !any_hit;
      rsp_target <= (dec_valid && any_hit) ? sel_tgt : '0;
      rsp_offset <= (dec_valid && any_hit) ? sel_off : '0;
    end
  end
endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int TGT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_err,
  input logic [TGT_W-1:0] rsp_target,
  input logic [63:0]      rsp_offset,
  input logic [63:0]      reg_rdata
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && reg_rdata == 64'h0));

  // R13
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(dec_valid));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_err));

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_err}) == 1));

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_offset == 64'h0 && rsp_target == '0));

  // R11
  offset_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_offset[63:32] == 32'h0));
endmodule

bind mmio_window_router mwr_checker #(.TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_target(rsp_target),
  .rsp_offset(rsp_offset), .reg_rdata(reg_rdata)
);

// File: tb/sim_mmio_window_router.sv
module sim_mmio_window_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_wide = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        dec_valid = 1'b0;
  logic [63:0] dec_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_err;
  logic [1:0]  rsp_target;
  logic [63:0] rsp_offset;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_regs [12];

  always #5 clk = ~clk;

  mmio_window_router u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .dec_valid(dec_valid), .dec_addr(dec_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_target(rsp_target), .rsp_offset(rsp_offset)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_decode(input logic [63:0] a, output logic [1:0] t,
                                  output logic [63:0] o);
    t = 2'd0;
    o = 64'h0;
    for (int n = 0; n < 4; n++) begin
      logic [31:0] b  = m_regs[3*n][31:0];
      logic [31:0] sz = (~m_regs[3*n+1][31:0] + 32'h1) & 32'hFFFF_F000;
      logic [63:0] eb = {32'hFFFF_FFFF, b & 32'hFFFF_F000};
      if (b[0] && sz != 0 && a >= eb && (a - eb) < {32'h0, sz}) begin
        t = m_regs[3*n+2][1:0];
        o = a - eb;
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [11:0] a, input logic [63:0] d, input bit full);
    reg_wr = 1'b1; reg_wide = full; reg_addr = a; reg_wdata = d;
    if (a >= 12'h300 && a < 12'h360) begin
      int i = int'((a - 12'h300) >> 3);
      if (full)      m_regs[i] = d;
      else if (a[2]) m_regs[i][63:32] = d[31:0];
      else           m_regs[i][31:0] = d[31:0];
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    logic [63:0] e;
    e = (a >= 12'h300 && a < 12'h360) ? m_regs[int'((a - 12'h300) >> 3)] : 64'h0;
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    chk({req, " rdata"}, reg_rdata, e);
    reg_rd = 1'b0;
  endtask

  task automatic dec(input logic [63:0] a, input string req);
    logic [1:0]  et;
    logic [63:0] eo;
    bit          eh;
    eh = m_decode(a, et, eo);
    dec_valid = 1'b1; dec_addr = a;
    @(negedge clk);
    chk({req, " R13 valid"}, {63'h0, rsp_valid}, 64'h1);
    chk({req, " hit"}, {63'h0, rsp_hit}, {63'h0, eh});
    chk({req, " R10 err"}, {63'h0, rsp_err}, {63'h0, !eh});
    chk({req, " R8 target"}, {62'h0, rsp_target}, {62'h0, et});
    chk({req, " R11 offset"}, rsp_offset, eo);
    dec_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 12; i++) m_regs[i] = 64'h0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 idle valid", {63'h0, rsp_valid}, 64'h0);
    for (int i = 0; i < 12; i++) rd(12'(12'h300 + 8*i), "R1");
    dec(64'hFFFF_FFFF_0000_0000, "R1 all disabled");

    // R6 R7 R8: window 0 start 0x80001000, size 1 MB, target 6 -> 2
    wr(12'h300, 64'h8000_0000_8000_1235, 1'b1);
    wr(12'h308, 64'h1234_5678_FFF0_0000, 1'b1);
    wr(12'h310, 64'h6, 1'b1);
    dec(64'hFFFF_FFFF_8000_1000, "R6 first byte");
    dec(64'hFFFF_FFFF_8010_0FFF, "R7 last byte");
    dec(64'hFFFF_FFFF_8010_1000, "R7 past end");
    dec(64'hFFFF_FFFF_8000_0FFF, "R6 below start");
    dec(64'h0000_0000_8000_1000, "R6 upper not forced");

    // R2 R3: half-word and full writes, out-of-block writes ignored
    wr(12'h314, 64'hFFFF_FFFF_0000_ABCD, 1'b0);
    rd(12'h310, "R2 upper half");
    wr(12'h310, 64'h1111_1111_0000_0003, 1'b0);
    rd(12'h310, "R2 lower half");
    wr(12'h318, 64'hCAFE_F00D_1234_5678, 1'b1);
    rd(12'h318, "R3 full");
    wr(12'h318, 64'h0, 1'b1);
    wr(12'h360, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    wr(12'h2F8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    rd(12'h360, "R2 outside");
    for (int i = 0; i < 12; i++) rd(12'(12'h300 + 8*i), "R2 untouched");

    // R9: window 1 overlaps window 0
    wr(12'h318, 64'h8000_0001, 1'b1);
    wr(12'h320, 64'hFFFF_0000, 1'b1);
    wr(12'h328, 64'h1, 1'b1);
    dec(64'hFFFF_FFFF_8000_2000, "R9 low index wins");
    // R4 R12: disable window 0, request on the next edge
    wr(12'h300, 64'h8000_1234, 1'b0);
    dec(64'hFFFF_FFFF_8000_2000, "R4 R12 disabled falls through");
    // R5: enabled but size rounds to zero
    wr(12'h320, 64'hFFFF_F800, 1'b0);
    dec(64'hFFFF_FFFF_8000_0000, "R5 zero size");
    wr(12'h320, 64'h0, 1'b0);
    dec(64'hFFFF_FFFF_8000_0000, "R5 zero mask");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 4);
      int n  = int'($urandom % 4);
      if (op == 0) begin
        int f = int'($urandom % 3);
        logic [63:0] d = {$urandom, $urandom};
        logic [11:0] a = 12'(12'h300 + 24*n + 8*f + (($urandom % 2) != 0 ? 4 : 0));
        bit full = ($urandom % 2) != 0;
        if (f == 1) d[31:0] = ~((32'h1 << (10 + $urandom % 12)) - 32'h1);
        if (f == 0) d[0] = ($urandom % 4) != 0;
        if (!full) begin
          if (a[2]) d[31:0] = d[63:32];
          else d[63:32] = $urandom;
        end
        wr(a, d, full);
      end else if (op == 3) begin
        if (($urandom % 2) != 0) rd(12'(12'h300 + 8*($urandom % 12)), "R2 R3 random");
        else dec({$urandom, $urandom}, "R10 random");
      end else begin
        logic [63:0] eb = {32'hFFFF_FFFF, m_regs[3*n][31:0] & 32'hFFFF_F000};
        logic [63:0] a  = eb + 64'($urandom % 32'h40_0000) - 64'(($urandom % 2) * 32'h1000);
        dec(a, "R7 R9 R11 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule